// File: doc/BRIEF.md
# PS/2 Host Receive Frame Decoder

This block listens to the open-drain clock and data lines of a PS/2 device and turns device-to-host frames into bytes. Both lines pass through two-flop synchronisers. The data line is sampled whenever the synchronised device clock falls. Each frame carries a low start bit, eight data bits sent least significant first, an odd parity bit and a high stop bit. Framing problems and inter-edge timeouts raise sticky error flags. Software reads these flags and clears them in one access.

A byte that passes every check goes to one of two places. If the host has armed a command-response wait, the byte lands in a dedicated response register and the wait is released. Otherwise the byte enters a small first-word-fall-through receive FIFO, which software drains through a pop interface. A companion transmitter can pull the enable input low to stop reception while it drives the lines itself.

Top module: `ps2rx_top`

## Requirements
- R1: Data is sampled on each falling edge of the synchronised device clock. A frame is start(0), data bits 0..7 least significant first, odd parity, stop(1). A good byte with no response wait armed is written to the FIFO, and bytes leave the FIFO in arrival order.
- R2: A start bit sampled as 1 sets error bit 0 (value 0x01). The decoder then counts edges until a bit count of 10 is reached, which covers the rest of an 11-edge frame. The frame after that decodes normally.
- R3: If the eight data bits plus the parity bit hold an even number of ones, error bit 2 (0x04) is set and the byte is discarded. The decoder swallows the stop edge and returns to idle.
- R4: A stop bit sampled as 0 sets error bit 3 (0x08) and discards the byte. After the stop edge the decoder is idle whatever the outcome.
- R5: Suppose the decoder is in mid-frame and more than TMO_CYC system clocks pass without a falling edge. The next falling edge then sets error bit 1 (0x02), abandons the partial frame, and is decoded as the start bit of a new frame.
- R6: Error flags are sticky and are visible on err_o. In a cycle with err_rd_i high, the value on err_o is the value returned, and the flags are cleared at the next edge. A flag raised in that same cycle survives the clear.
- R7: While rsp_pending_o is high, a good byte is stored in rsp_byte_o, the FIFO is not written, and rsp_pending_o falls. A pulse on rsp_arm_i sets rsp_pending_o.
- R8: A good byte that arrives when the FIFO holds DEPTH entries sets error bit 4 (0x10) and is dropped. The stored entries are kept.
- R9: pop_i removes the head entry when the FIFO is not empty and has no effect when empty_o is high. level_o always equals the number of stored entries, including when a push and a pop happen in the same cycle.
- R10: While rx_en is low, clock edges are ignored and the decoder is held idle. A partial frame interrupted this way leaves no error, and the next complete frame after rx_en returns high decodes normally.
- R11: After reset the FIFO is empty, level_o is 0, err_o is 0 and rsp_pending_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable; low forces idle and ignores edges |
| ps2_clk_i | input | 1 | Device clock line, asynchronous |
| ps2_dat_i | input | 1 | Device data line, asynchronous |
| pop_i | input | 1 | Remove the FIFO head entry |
| rd_data_o | output | 8 | FIFO head entry |
| empty_o | output | 1 | FIFO holds no entry |
| level_o | output | $clog2(DEPTH+1) | Number of FIFO entries |
| rsp_arm_i | input | 1 | Arm a command-response wait |
| rsp_pending_o | output | 1 | Command-response wait is armed |
| rsp_byte_o | output | 8 | Last captured command-response byte |
| err_rd_i | input | 1 | Read-and-clear strobe for the error flags |
| err_o | output | 5 | Sticky error flags: bit0 start, bit1 timeout, bit2 parity, bit3 stop, bit4 overflow |

## Verification
The bench sends a start-bit error frame and then a good frame. A decoder that resynchronised at once, instead of draining the whole frame, would take a data edge of the bad frame as a start bit and then log a run of false errors and wrong bytes. A parity error has to consume exactly the stop edge. A gap longer than the timeout must turn its closing edge into a start bit, and a design that dropped that edge instead would lose the byte that follows. The bench also fills the FIFO to overflow, routes a byte to the response register, and drops rx_en in mid-frame. A wrong design would write the FIFO twice, overwrite stored entries, or report a spurious timeout after reception resumes.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    // Decoder phases of one device-to-host frame
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_DRAIN
    } rx_state_e;

    localparam int BYTE_W     = 8;
    localparam int ERR_W      = 5;
    localparam int FRAME_BITS = 11;
    // Edge count at which the drain phase gives up on a broken frame
    localparam logic [3:0] DRAIN_END = 4'(FRAME_BITS - 1);

    // Sticky error flags; bit order is visible at err_o
    typedef struct packed {
        logic ovf;    // bit 4
        logic stop;   // bit 3
        logic par;    // bit 2
        logic tmo;    // bit 1
        logic start;  // bit 0
    } rx_err_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
    } rx_byte_t;

    // Width of a counter that must reach n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int         W       = 2,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RST_VAL;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ps2rx_frame.sv
module ps2rx_frame
    import ps2rx_pkg::*;
#(
    parameter int TMO_CYC = 200000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     fall,
    input  logic     dat,
    output rx_byte_t good,
    output rx_err_t  err_pulse,
    output logic     busy
);
    localparam int TW = cnt_width(TMO_CYC + 1);
    localparam logic [TW-1:0] TMO_LIM = TW'(TMO_CYC);
    localparam logic [TW-1:0] TMO_SAT = TW'(TMO_CYC + 1);

    rx_state_e         state_q;
    rx_state_e         eff_state;
    logic [BYTE_W-1:0] shreg_q;
    logic [3:0]        cnt_q;
    logic              ones_q;
    logic [TW-1:0]     gap_q;
    logic              gap_exp;
    logic              tmo_evt;

    // Cycles since the last falling edge, only counted inside a frame
    always_ff @(posedge clk) begin
        if (rst || !en || state_q == ST_IDLE || fall)
            gap_q <= '0;
        else if (gap_q != TMO_SAT)
            gap_q <= gap_q + 1'b1;
    end

    assign gap_exp   = (gap_q > TMO_LIM);
    assign tmo_evt   = fall && (state_q != ST_IDLE) && gap_exp;
    assign eff_state = tmo_evt ? ST_IDLE : state_q;

    always_ff @(posedge clk) begin
        good.vld  <= 1'b0;
        err_pulse <= '0;
        if (rst) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            cnt_q    <= '0;
            ones_q   <= 1'b0;
            good.dat <= '0;
        end else if (!en) begin
            state_q <= ST_IDLE;
        end else if (fall) begin
            err_pulse.tmo <= tmo_evt;
            unique case (eff_state)
                ST_IDLE: begin
                    shreg_q <= '0;
                    cnt_q   <= '0;
                    ones_q  <= 1'b0;
                    if (dat) begin
                        err_pulse.start <= 1'b1;
                        state_q         <= ST_DRAIN;
                    end else begin
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    shreg_q <= {dat, shreg_q[BYTE_W-1:1]};
                    ones_q  <= ones_q ^ dat;
                    cnt_q   <= cnt_q + 4'd1;
                    if (cnt_q == 4'(BYTE_W - 1)) state_q <= ST_PAR;
                end
                ST_PAR: begin
                    cnt_q <= cnt_q + 4'd1;
                    if (ones_q ^ dat) begin
                        state_q <= ST_STOP;
                    end else begin
                        err_pulse.par <= 1'b1;
                        state_q       <= ST_DRAIN;
                    end
                end
                ST_STOP: begin
                    cnt_q <= cnt_q + 4'd1;
                    if (!dat) begin
                        err_pulse.stop <= 1'b1;
                    end else begin
                        good.vld <= 1'b1;
                        good.dat <= shreg_q;
                    end
                    state_q <= ST_IDLE;
                end
                ST_DRAIN: begin
                    cnt_q <= cnt_q + 4'd1;
                    if (cnt_q + 4'd1 >= DRAIN_END) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/ps2rx_fifo.sv
module ps2rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= nxt(wptr_q);
            if (do_pop)  rptr_q <= nxt(rptr_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rptr_q];
    assign level = cnt_q;
endmodule

// File: rtl/ps2rx_top.sv
module ps2rx_top
    import ps2rx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TMO_CYC = 200000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_en,
    input  logic                       ps2_clk_i,
    input  logic                       ps2_dat_i,
    input  logic                       pop_i,
    output logic [7:0]                 rd_data_o,
    output logic                       empty_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    input  logic                       rsp_arm_i,
    output logic                       rsp_pending_o,
    output logic [7:0]                 rsp_byte_o,
    input  logic                       err_rd_i,
    output logic [4:0]                 err_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0] line_s;
    logic       clk_s, dat_s, clk_d;
    logic       fall;
    rx_byte_t   good;
    rx_err_t    frm_err, err_q, new_err;
    logic       frm_busy;
    logic       good_vld;
    logic       fifo_full, fifo_push, ovf_evt;
    logic       pend_q;
    logic [7:0] rsp_q;

    ps2rx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ps2_clk_i, ps2_dat_i}),
        .q   (line_s)
    );
    assign clk_s = line_s[1];
    assign dat_s = line_s[0];

    always_ff @(posedge clk) begin
        if (rst) clk_d <= 1'b1;
        else     clk_d <= clk_s;
    end
    assign fall = clk_d && !clk_s;

    ps2rx_frame #(.TMO_CYC(TMO_CYC)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .fall      (fall),
        .dat       (dat_s),
        .good      (good),
        .err_pulse (frm_err),
        .busy      (frm_busy)
    );
    assign good_vld = good.vld;

    // Routing of a good byte: response register first, FIFO otherwise
    assign fifo_push = good_vld && !pend_q && !fifo_full;
    assign ovf_evt   = good_vld && !pend_q && fifo_full;

    ps2rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .wdata (good.dat),
        .pop   (pop_i),
        .rdata (rd_data_o),
        .full  (fifo_full),
        .empty (empty_o),
        .level (level_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rsp_q  <= '0;
        end else begin
            if (good_vld && pend_q) rsp_q <= good.dat;
            pend_q <= rsp_arm_i || (pend_q && !good_vld);
        end
    end

    always_comb begin
        new_err     = frm_err;
        new_err.ovf = ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= (err_rd_i ? rx_err_t'('0) : err_q) | new_err;
    end

    assign err_o         = err_q;
    assign rsp_pending_o = pend_q;
    assign rsp_byte_o    = rsp_q;
endmodule

// File: rtl/ps2rx_chk.sv
module ps2rx_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          pop_i,
    input logic          err_rd_i,
    input logic          rsp_arm_i,
    input logic          empty_o,
    input logic [CW-1:0] level_o,
    input logic [4:0]    err_o,
    input logic          rsp_pending_o,
    input logic          busy,
    input logic          good_vld,
    input logic          push
);
    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level_o <= CW'(DEPTH));

    // R9
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o && !push) |=> (level_o == '0));

    // R10
    en_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !busy);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !err_rd_i |=> ((err_o & $past(err_o)) == $past(err_o)));

    // R7
    rsp_route_chk: assert property (@(posedge clk) disable iff (rst)
        (good_vld && rsp_pending_o && !rsp_arm_i && !pop_i)
            |=> (!rsp_pending_o && $stable(level_o)));
endmodule

bind ps2rx_top ps2rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rx_en         (rx_en),
    .pop_i         (pop_i),
    .err_rd_i      (err_rd_i),
    .rsp_arm_i     (rsp_arm_i),
    .empty_o       (empty_o),
    .level_o       (level_o),
    .err_o         (err_o),
    .rsp_pending_o (rsp_pending_o),
    .busy          (frm_busy),
    .good_vld      (good_vld),
    .push          (fifo_push)
);

// File: tb/tb_ps2rx_top.sv
module tb_ps2rx_top;
    localparam int DEPTH = 4;
    localparam int TMO   = 400;
    localparam int HP    = 20;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_en = 1'b1;
    logic          ps2_clk = 1'b1, ps2_dat = 1'b1;
    logic          tb_pop = 1'b0, mon_pop = 1'b0, pop_i;
    logic [7:0]    rd_data;
    logic          empty;
    logic [CW-1:0] level;
    logic          rsp_arm = 1'b0, rsp_pending;
    logic [7:0]    rsp_byte;
    logic          err_rd = 1'b0;
    logic [4:0]    err;

    int n_chk = 0, n_bad = 0, mon_cnt = 0, cyc = 0;
    bit mon_en = 1'b0;
    logic [7:0] expq [$];

    always #2.5 clk = ~clk;
    assign pop_i = tb_pop | mon_pop;

    ps2rx_top #(.DEPTH(DEPTH), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .rx_en(rx_en),
        .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .pop_i(pop_i), .rd_data_o(rd_data), .empty_o(empty), .level_o(level),
        .rsp_arm_i(rsp_arm), .rsp_pending_o(rsp_pending), .rsp_byte_o(rsp_byte),
        .err_rd_i(err_rd), .err_o(err)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Monitor: pops FIFO entries and compares them with the scoreboard (R1)
    always @(negedge clk) begin
        mon_pop <= 1'b0;
        if (mon_en && !empty && !mon_pop) begin
            n_chk++;
            mon_cnt++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R1: unexpected byte got 0x%0h expected none", rd_data);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL R1: byte got 0x%0h expected 0x%0h", rd_data, e);
                end
            end
            mon_pop <= 1'b1;
        end
    end

    function automatic logic [10:0] mk_frame(input logic [7:0] b, input logic st,
                                             input logic flip, input logic sp);
        return {sp, (~^b) ^ flip, b, st};
    endfunction

    task automatic send_bits(input logic [10:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            ps2_dat = f[i];
            repeat (HP) @(negedge clk);
            ps2_clk = 1'b0;
            repeat (HP) @(negedge clk);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Driver: good frame whose byte is expected from the FIFO
    task automatic send_good(input logic [7:0] b);
        expq.push_back(b);
        send_bits(mk_frame(b, 1'b0, 1'b0, 1'b1), 11);
    endtask

    task automatic rd_err(input string req, input int exp);
        @(negedge clk);
        check(req, err, exp);
        err_rd = 1'b1;
        @(negedge clk);
        err_rd = 1'b0;
        check("R6 clear", err, 0);
    endtask

    task automatic drain_wait();
        repeat (20) @(negedge clk);
        check("R1 scoreboard empty", expq.size(), 0);
    endtask

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 empty", empty, 1);
        check("R11 level", level, 0);
        check("R11 err", err, 0);
        check("R11 pending", rsp_pending, 0);

        // R9 pop on empty has no effect
        tb_pop = 1'b1;
        @(negedge clk);
        tb_pop = 1'b0;
        @(negedge clk);
        check("R9 pop empty level", level, 0);
        check("R9 pop empty flag", empty, 1);

        // R1 several patterns, LSB first, in order
        mon_en = 1'b1;
        send_good(8'h00);
        send_good(8'hFF);
        send_good(8'hA5);
        send_good(8'h3C);
        send_good(8'h81);
        drain_wait();
        check("R1 count", mon_cnt, 5);

        // R3 parity error, byte dropped, stop edge consumed
        base = mon_cnt;
        send_bits(mk_frame(8'hA5, 1'b0, 1'b1, 1'b1), 11);
        check("R3 no byte", mon_cnt, base);
        rd_err("R3 parity flag", 5'h04);
        send_good(8'h5A);
        drain_wait();
        check("R3 next frame err", err, 0);

        // R2 start error drains a whole frame
        send_bits(mk_frame(8'h55, 1'b1, 1'b0, 1'b1), 11);
        rd_err("R2 start flag", 5'h01);
        send_good(8'h12);
        drain_wait();
        check("R2 next frame err", err, 0);

        // R4 stop error discards byte
        base = mon_cnt;
        send_bits(mk_frame(8'h66, 1'b0, 1'b0, 1'b0), 11);
        check("R4 no byte", mon_cnt, base);
        check("R4 stop flag", err, 5'h08);

        // R5 timeout: partial frame, long gap, edge becomes a start bit
        send_bits(mk_frame(8'h77, 1'b0, 1'b0, 1'b1), 5);
        repeat (3 * TMO) @(negedge clk);
        send_good(8'h34);
        drain_wait();
        // R6 sticky: stop flag kept alongside timeout
        rd_err("R5 R6 timeout plus sticky stop", 5'h0A);

        // R7 response routing
        base = mon_cnt;
        @(negedge clk);
        rsp_arm = 1'b1;
        @(negedge clk);
        rsp_arm = 1'b0;
        check("R7 armed", rsp_pending, 1);
        send_bits(mk_frame(8'hC3, 1'b0, 1'b0, 1'b1), 11);
        check("R7 rsp byte", rsp_byte, 8'hC3);
        check("R7 released", rsp_pending, 0);
        check("R7 fifo untouched", mon_cnt, base);
        check("R7 level", level, 0);

        // R8 overflow
        mon_en = 1'b0;
        send_good(8'h01);
        send_good(8'h02);
        send_good(8'h03);
        send_good(8'h04);
        send_bits(mk_frame(8'hEE, 1'b0, 1'b0, 1'b1), 11);
        check("R8 level full", level, DEPTH);
        rd_err("R8 overflow flag", 5'h10);
        mon_en = 1'b1;
        drain_wait();
        check("R9 drained", level, 0);

        // R10 disabled reception ignores a frame
        base = mon_cnt;
        rx_en = 1'b0;
        send_bits(mk_frame(8'h99, 1'b0, 1'b0, 1'b1), 11);
        check("R10 ignored byte", mon_cnt, base);
        check("R10 ignored err", err, 0);
        rx_en = 1'b1;
        // R10 mid-frame disable, then clean frame
        send_bits(mk_frame(8'h0F, 1'b0, 1'b0, 1'b1), 4);
        rx_en = 1'b0;
        repeat (5) @(negedge clk);
        rx_en = 1'b1;
        repeat (5) @(negedge clk);
        send_good(8'h42);
        drain_wait();
        check("R10 no error after resume", err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule